// File: doc/BRIEF.md
# DMA Address Sequence Generator

This block produces the address, transfer size and byte-enable mask for one side of a DMA channel. A channel controller loads it with a 3-bit sequence code and a start address. After that, each transfer-done strobe moves the address forward by the step that the code selects. The same encoding serves both directions, so a channel uses one instance for reads and a second instance for writes. Bus signalling, data movement and length counting are handled elsewhere.

Six codes are defined. Three increment the address: by one byte, by one halfword, or by a size taken from the alignment of the start address. Three hold the address fixed: a single byte, a single halfword, or a word burst. The two remaining codes are reserved. Loading a reserved code raises a sticky configuration error and blocks every transfer until a valid code is loaded.

The control is a three-state machine. `ST_IDLE` is the state after reset, before any configuration. `ST_RUN` means a valid configuration is active. `ST_FAULT` means a reserved code was loaded. There are three named transitions:
- LOAD_OK: a load with a valid code, taken from any state, enters `ST_RUN`.
- LOAD_BAD: a load with a reserved code, taken from any state, enters `ST_FAULT`.
- ADVANCE: the self-loop of `ST_RUN` when a transfer completes.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, `seq_valid`=0, `cfg_err`=0, `addr_out`=0, `size_out`=0, `byte_en`=0 and `burst`=0.
- R2: Code 3'b000 gives byte size (`size_out`=2'd0) and adds 1 to the address on each `xfer_done`. `byte_en` is 4'b0001 shifted left by `addr_out[1:0]`.
- R3: Code 3'b001 gives halfword size (`size_out`=2'd1). The start address has bit 0 cleared, and the address adds 2 on each `xfer_done`. `byte_en` is 4'b0011 shifted left by 2*`addr_out[1]`.
- R4: Code 3'b010 picks the size from the start address. If bits [1:0] are 0 the size is word (`size_out`=2'd2, `byte_en`=4'hF). Otherwise, if bit 0 is 0 the size is halfword. Otherwise the size is byte. Each `xfer_done` adds 1, 2 or 4 to match that size.
- R5: Code 3'b011 holds a fixed byte address. `byte_en` is 4'b0001 shifted left by `addr_out[1:0]`, and `xfer_done` does not change the address.
- R6: Code 3'b100 holds a fixed halfword address with bit 0 cleared, at halfword size. `xfer_done` does not change the address.
- R7: Code 3'b101 holds a fixed word address with bits [1:0] cleared, at word size, with `byte_en`=4'hF and `burst`=1. `burst` is 0 under every other code.
- R8: Loading code 3'b110 or 3'b111 sets `cfg_err`=1 one cycle later and clears `seq_valid`, `byte_en`, `burst` and `size_out`. It leaves `addr_out` at its previous value. `cfg_err` stays set and the address does not move on `xfer_done` until the next valid load.
- R9: A valid load clears `cfg_err` and sets `seq_valid` one cycle later. When `load` and `xfer_done` are high in the same cycle, the load wins and no advance occurs. The address changes only on a load or on `xfer_done`.
- R10: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that captures `seq_code` and `start_addr` |
| seq_code | input | 3 | Address sequence code |
| start_addr | input | ADDR_W | Start address for the sequence |
| xfer_done | input | 1 | One transfer finished; advance the address |
| addr_out | output | ADDR_W | Current transfer address |
| size_out | output | 2 | Transfer size: 0 = byte, 1 = halfword, 2 = word |
| byte_en | output | 4 | Lane enable mask |
| burst | output | 1 | Word-burst mode is active |
| seq_valid | output | 1 | A valid configuration is active |
| cfg_err | output | 1 | A reserved code was loaded (sticky) |

## Verification
A corrupted stored mode appears at the ports in the first cycle after a load. It shows as a wrong `size_out` or `byte_en`, or as a `burst` flag that does not agree with the mask. A wrong step or a wrong fixed/increment choice only appears after a transfer-done strobe. For that reason each vector applies several strobes before it compares the address, and a single-byte error is visible after one extra cycle. A state machine stuck in the wrong state shows at once as a mismatch between `seq_valid` and `cfg_err` following a load.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    localparam logic [2:0] CODE_INC_BYTE = 3'b000;
    localparam logic [2:0] CODE_INC_HALF = 3'b001;
    localparam logic [2:0] CODE_INC_AUTO = 3'b010;
    localparam logic [2:0] CODE_FIX_BYTE = 3'b011;
    localparam logic [2:0] CODE_FIX_HALF = 3'b100;
    localparam logic [2:0] CODE_FIX_WORD = 3'b101;

    typedef struct packed {
        logic       reserved;
        logic       fixed;
        logic       burst;
        xfer_size_e size;
    } seq_mode_t;

endpackage

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        code,
    input  logic [ADDR_W-1:0] base,
    output seq_mode_t         mode,
    output logic [ADDR_W-1:0] first_addr
);

    always_comb begin
        mode       = '{reserved: 1'b0, fixed: 1'b0, burst: 1'b0, size: SZ_BYTE};
        first_addr = base;
        case (code)
            CODE_INC_BYTE: begin
                mode.size = SZ_BYTE;
            end
            CODE_INC_HALF: begin
                mode.size     = SZ_HALF;
                first_addr[0] = 1'b0;
            end
            CODE_INC_AUTO: begin
                if (base[1:0] == 2'b00) begin
                    mode.size = SZ_WORD;
                end else if (base[0] == 1'b0) begin
                    mode.size = SZ_HALF;
                end else begin
                    mode.size = SZ_BYTE;
                end
            end
            CODE_FIX_BYTE: begin
                mode.fixed = 1'b1;
                mode.size  = SZ_BYTE;
            end
            CODE_FIX_HALF: begin
                mode.fixed    = 1'b1;
                mode.size     = SZ_HALF;
                first_addr[0] = 1'b0;
            end
            CODE_FIX_WORD: begin
                mode.fixed      = 1'b1;
                mode.burst      = 1'b1;
                mode.size       = SZ_WORD;
                first_addr[1:0] = 2'b00;
            end
            default: begin
                mode.reserved = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dma_seq_benable.sv
module dma_seq_benable
    import dma_seq_pkg::*;
(
    input  logic       enable,
    input  xfer_size_e size,
    input  logic [1:0] low_addr,
    output logic [3:0] lanes
);

    always_comb begin
        lanes = 4'b0000;
        if (enable) begin
            unique case (size)
                SZ_BYTE: lanes = 4'b0001 << low_addr;
                SZ_HALF: lanes = low_addr[1] ? 4'b1100 : 4'b0011;
                SZ_WORD: lanes = 4'b1111;
                default: lanes = 4'b0000;
            endcase
        end
    end

endmodule

// File: rtl/dma_seq_stepper.sv
module dma_seq_stepper
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  seq_mode_t         mode,
    output logic [ADDR_W-1:0] next_addr
);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step = '0;
        if (!mode.fixed) begin
            step = ADDR_W'(1) << mode.size;
        end
        next_addr = cur_addr + step;
    end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [2:0]        seq_code,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        size_out,
    output logic [3:0]        byte_en,
    output logic              burst,
    output logic              seq_valid,
    output logic              cfg_err
);

    seq_state_e        state_q;
    seq_state_e        state_d;
    seq_mode_t         mode_q;
    seq_mode_t         dec_mode;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] dec_first;
    logic [ADDR_W-1:0] adv_addr;
    logic              running;

    dma_seq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .code       (seq_code),
        .base       (start_addr),
        .mode       (dec_mode),
        .first_addr (dec_first)
    );

    dma_seq_stepper #(.ADDR_W(ADDR_W)) u_stepper (
        .cur_addr  (addr_q),
        .mode      (mode_q),
        .next_addr (adv_addr)
    );

    // Next state: LOAD_OK / LOAD_BAD from any state; ADVANCE stays in ST_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RUN, ST_FAULT: begin
                if (load) begin
                    state_d = dec_mode.reserved ? ST_FAULT : ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Address and mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mode_q <= '{reserved: 1'b0, fixed: 1'b0, burst: 1'b0, size: SZ_BYTE};
        end else if (load) begin
            if (!dec_mode.reserved) begin
                addr_q <= dec_first;
                mode_q <= dec_mode;
            end
        end else if (state_q == ST_RUN && xfer_done) begin
            addr_q <= adv_addr;
        end
    end

    assign running   = (state_q == ST_RUN);
    assign addr_out  = addr_q;
    assign seq_valid = running;
    assign cfg_err   = (state_q == ST_FAULT);
    assign burst     = running & mode_q.burst;
    assign size_out  = running ? mode_q.size : SZ_BYTE;

    dma_seq_benable u_benable (
        .enable   (running),
        .size     (mode_q.size),
        .low_addr (addr_q[1:0]),
        .lanes    (byte_en)
    );

endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic [2:0]        seq_code,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        size_out,
    input logic [3:0]        byte_en,
    input logic              burst,
    input logic              seq_valid,
    input logic              cfg_err
);

    assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_valid |-> ($countones(byte_en) == (32'd1 << size_out)));

    assert_burst_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst |-> (size_out == 2'd2 && byte_en == 4'hF));

    assert_burst_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && xfer_done && !load) |=> $stable(addr_out));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!seq_valid && byte_en == 4'h0 && !burst));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !load) |=> cfg_err);

    assert_bad_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seq_code[2:1] == 2'b11) |=> cfg_err);

    assert_good_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seq_code[2:1] != 2'b11) |=> (seq_valid && !cfg_err));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !xfer_done) |=> $stable(addr_out));

endmodule

bind dma_addr_seq dma_seq_checker #(.ADDR_W(ADDR_W)) u_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .seq_code  (seq_code),
    .xfer_done (xfer_done),
    .addr_out  (addr_out),
    .size_out  (size_out),
    .byte_en   (byte_en),
    .burst     (burst),
    .seq_valid (seq_valid),
    .cfg_err   (cfg_err)
);

// File: tb/test_dma_addr_seq.sv
module test_dma_addr_seq;

    localparam int AW = 32;
    localparam int NV = 14;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  code;
        logic [31:0] start;
        logic [3:0]  pulses;
        logic [31:0] exp_addr;
        logic [1:0]  exp_size;
        logic [3:0]  exp_be;
        logic        exp_burst;
        logic        exp_err;
        logic        exp_valid;
    } vec_t;

    // req, code, start, pulses, addr, size, be, burst, err, valid
    localparam vec_t VECS [NV] = '{
        '{4'd2,  3'd0, 32'h1000_0002, 4'd3, 32'h1000_0005, 2'd0, 4'b0010, 1'b0, 1'b0, 1'b1}, // R2
        '{4'd2,  3'd0, 32'h0000_0003, 4'd0, 32'h0000_0003, 2'd0, 4'b1000, 1'b0, 1'b0, 1'b1}, // R2
        '{4'd3,  3'd1, 32'h0000_0101, 4'd1, 32'h0000_0102, 2'd1, 4'b1100, 1'b0, 1'b0, 1'b1}, // R3
        '{4'd3,  3'd1, 32'h0000_0200, 4'd2, 32'h0000_0204, 2'd1, 4'b0011, 1'b0, 1'b0, 1'b1}, // R3
        '{4'd4,  3'd2, 32'h0000_0400, 4'd3, 32'h0000_040C, 2'd2, 4'b1111, 1'b0, 1'b0, 1'b1}, // R4
        '{4'd4,  3'd2, 32'h0000_0402, 4'd2, 32'h0000_0406, 2'd1, 4'b1100, 1'b0, 1'b0, 1'b1}, // R4
        '{4'd4,  3'd2, 32'h0000_0403, 4'd2, 32'h0000_0405, 2'd0, 4'b0010, 1'b0, 1'b0, 1'b1}, // R4
        '{4'd5,  3'd3, 32'h0000_0007, 4'd4, 32'h0000_0007, 2'd0, 4'b1000, 1'b0, 1'b0, 1'b1}, // R5
        '{4'd6,  3'd4, 32'h0000_0013, 4'd3, 32'h0000_0012, 2'd1, 4'b1100, 1'b0, 1'b0, 1'b1}, // R6
        '{4'd7,  3'd5, 32'h0000_002B, 4'd5, 32'h0000_0028, 2'd2, 4'b1111, 1'b1, 1'b0, 1'b1}, // R7
        '{4'd8,  3'd6, 32'h0000_0050, 4'd2, 32'h0000_0028, 2'd0, 4'b0000, 1'b0, 1'b1, 1'b0}, // R8
        '{4'd8,  3'd7, 32'h0000_0060, 4'd3, 32'h0000_0028, 2'd0, 4'b0000, 1'b0, 1'b1, 1'b0}, // R8
        '{4'd10, 3'd0, 32'hFFFF_FFFE, 4'd3, 32'h0000_0001, 2'd0, 4'b0010, 1'b0, 1'b0, 1'b1}, // R10, R9 clears error
        '{4'd10, 3'd2, 32'hFFFF_FFFC, 4'd1, 32'h0000_0000, 2'd2, 4'b1111, 1'b0, 1'b0, 1'b1}  // R10
    };

    logic          clk;
    logic          rst_n;
    logic          load;
    logic [2:0]    seq_code;
    logic [AW-1:0] start_addr;
    logic          xfer_done;
    logic [AW-1:0] addr_out;
    logic [1:0]    size_out;
    logic [3:0]    byte_en;
    logic          burst;
    logic          seq_valid;
    logic          cfg_err;

    int checks = 0;
    int errors = 0;

    dma_addr_seq #(.ADDR_W(AW)) i_dma_addr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .seq_code   (seq_code),
        .start_addr (start_addr),
        .xfer_done  (xfer_done),
        .addr_out   (addr_out),
        .size_out   (size_out),
        .byte_en    (byte_en),
        .burst      (burst),
        .seq_valid  (seq_valid),
        .cfg_err    (cfg_err)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_load(input logic [2:0] c, input logic [31:0] a, input logic with_done);
        @(negedge clk);
        load       = 1'b1;
        seq_code   = c;
        start_addr = a;
        xfer_done  = with_done;
        @(negedge clk);
        load      = 1'b0;
        xfer_done = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic check_reset_state();
        check(1, "addr",  addr_out, 32'h0);
        check(1, "size",  32'(size_out), 32'h0);
        check(1, "be",    32'(byte_en), 32'h0);
        check(1, "burst", 32'(burst), 32'h0);
        check(1, "valid", 32'(seq_valid), 32'h0);
        check(1, "err",   32'(cfg_err), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        load       = 1'b0;
        seq_code   = 3'd0;
        start_addr = '0;
        xfer_done  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state(); // R1

        // xfer_done before any configuration moves nothing (R9)
        pulse_done();
        check(9, "addr idle", addr_out, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].code, VECS[i].start, 1'b0);
            for (int p = 0; p < int'(VECS[i].pulses); p++) begin
                pulse_done();
            end
            check(int'(VECS[i].req), "addr",  addr_out, VECS[i].exp_addr);
            check(int'(VECS[i].req), "size",  32'(size_out), 32'(VECS[i].exp_size));
            check(int'(VECS[i].req), "be",    32'(byte_en), 32'(VECS[i].exp_be));
            check(int'(VECS[i].req), "burst", 32'(burst), 32'(VECS[i].exp_burst));
            check(int'(VECS[i].req), "err",   32'(cfg_err), 32'(VECS[i].exp_err));
            check(int'(VECS[i].req), "valid", 32'(seq_valid), 32'(VECS[i].exp_valid));
        end

        // R9: load wins over a simultaneous xfer_done
        do_load(3'd0, 32'h0000_0080, 1'b1);
        check(9, "load priority", addr_out, 32'h0000_0080);
        repeat (3) @(negedge clk);
        check(9, "hold w/o strobe", addr_out, 32'h0000_0080);
        pulse_done();
        check(9, "advance after hold", addr_out, 32'h0000_0081);

        // R8: reserved load keeps address, then a valid load recovers (R9)
        do_load(3'd7, 32'h0000_0F00, 1'b0);
        check(8, "err set", 32'(cfg_err), 32'h1);
        check(8, "addr kept", addr_out, 32'h0000_0081);
        do_load(3'd1, 32'h0000_0F03, 1'b0);
        check(9, "err cleared", 32'(cfg_err), 32'h0);
        check(3, "half align", addr_out, 32'h0000_0F02);

        // R1: reset in mid operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule